// File: doc/BRIEF.md
# Two-Wire Serial Command Receiver

This block takes a one-byte command from an external controller over two wires. One wire carries data and the other carries a bit clock, and both rest high. A frame opens when the data wire falls while the receiver is idle. At that moment the receiver raises a one-cycle abort strobe so that the surrounding logic drops whatever it is doing. The receiver then waits for the data wire to stay low for a debounce interval. Once the interval has passed, it clears its bit counter and shift register.

After that, bits are taken on rising edges of the bit clock, least significant bit first. A frame closes once eight bits are held and both wires are high. When the last bit is 1, this happens at the eighth clock rise. When the last bit is 0, it happens when the data wire goes back high while the clock is high. On closing, the byte appears on a command output with a one-cycle valid strobe and is used as an interrupt vector. A service-busy flag then stays high until the playback engine reports that it is done.

Both wires pass through a two-flop synchronizer, and all edge detection runs on the synchronized copies. A frame that closes with any bit count other than eight is dropped: it produces no strobe and does not raise busy.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `busy_o`, `cmd_valid_o` and `abort_o` are 0, and `cmd_byte_o` is 8'h00.
- R2: A falling data wire while idle produces exactly one `abort_o` pulse, and that pulse also clears `busy_o`.
- R3: If the data wire returns high before DEB_CYCLES cycles of continuous low, the receiver returns to idle. No strobe is issued and busy stays 0.
- R4: Rising edges of the bit clock that arrive during the debounce interval are not counted as data bits.
- R5: Bits are sampled on synchronized rising edges of the bit clock. The first bit lands in `cmd_byte_o[0]` and the eighth in `cmd_byte_o[7]`. `cmd_valid_o` lasts exactly one cycle.
- R6: With eight bits held, the frame closes as soon as both wires are high. For a final bit of 1 this is the eighth clock rise. For a final bit of 0 it is the data return, and `cmd_valid_o` comes exactly two cycles after the data wire is seen high at a clock edge.
- R7: A frame that ends (data rising while the clock is high) with a count other than eight is discarded. The bit count restarts from zero on every new frame.
- R8: `busy_o` rises in the same cycle as `cmd_valid_o` and falls the cycle after `play_done_i`. If `play_done_i` and `cmd_valid_o` fall in the same cycle, busy ends up high.
- R9: `cmd_byte_o` changes only in a cycle where `cmd_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdat_i | input | 1 | Serial data wire, idle high, asynchronous |
| sclk_i | input | 1 | Serial bit clock wire, idle high, asynchronous |
| play_done_i | input | 1 | Playback finished pulse, clears busy |
| abort_o | output | 1 | One-cycle stop strobe at frame start |
| cmd_valid_o | output | 1 | One-cycle strobe: received byte is valid |
| cmd_byte_o | output | 8 | Received command byte (vector number) |
| busy_o | output | 1 | Service busy, from accepted command until playback done |

## Verification
A received command and the end of playback can land in the same cycle: the command sets busy while the done pulse clears it. The bench provokes this by counting the synchronizer stages from the data return. It drives `play_done_i` for the one edge on which `cmd_valid_o` is registered. It then requires that valid is seen in that cycle and that busy is still high afterwards. A second done pulse must then clear busy, which shows the overlap was resolved in favour of the new command and did not leave busy stuck.

// File: rtl/serial_cmd_rx_pkg.sv
package serial_cmd_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DEB  = 2'd1,
    RX_BITS = 2'd2
  } rx_state_e;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  // lines rest high, so reset to the idle level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= stage_d;
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/scr_deb_timer.sv
module scr_deb_timer #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)             cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // R3
  deb_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(run_i));
endmodule

// File: rtl/scr_shift.sv
module scr_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (shift_i) begin
      sh_d = {bit_i, sh_q[BYTE_W-1:1]};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign data_o = sh_q;
  assign full_o = (cnt_q == CNT_FULL);

  // R7
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !full_o);
  // R5
  msb_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clr_i) |=> (data_o[BYTE_W-1] == $past(bit_i)));
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_rx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int DEB_CYCLES = 16,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdat_i,
  input  logic              sclk_i,
  input  logic              play_done_i,
  output logic              abort_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_byte_o,
  output logic              busy_o
);
  logic [1:0] sync_w;
  logic       dat_s, clk_s, dat_q, clk_q;
  logic       dat_fall, dat_rise, clk_rise;

  scr_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({sdat_i, sclk_i}), .sync_o(sync_w)
  );
  assign dat_s = sync_w[1];
  assign clk_s = sync_w[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= 1'b1;
      clk_q <= 1'b1;
    end else begin
      dat_q <= dat_s;
      clk_q <= clk_s;
    end
  end

  assign dat_fall = dat_q & ~dat_s;
  assign dat_rise = ~dat_q & dat_s;
  assign clk_rise = ~clk_q & clk_s;

  rx_state_e         state_q, state_d;
  logic              abort_d, valid_d, busy_d;
  logic [BYTE_W-1:0] byte_d;
  logic              deb_run, deb_done;
  logic              sh_clr, sh_en, sh_full;
  logic [BYTE_W-1:0] sh_data;

  assign deb_run = (state_q == RX_DEB) && !dat_s;

  scr_deb_timer #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .run_i(deb_run), .done_o(deb_done)
  );

  scr_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr_i(sh_clr), .shift_i(sh_en),
    .bit_i(dat_s), .data_o(sh_data), .full_o(sh_full)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    abort_d = 1'b0;
    valid_d = 1'b0;
    byte_d  = cmd_byte_o;
    busy_d  = busy_o;
    sh_clr  = 1'b0;
    sh_en   = 1'b0;
    if (play_done_i) busy_d = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (dat_fall) begin
          abort_d = 1'b1;
          busy_d  = 1'b0;
          state_d = RX_DEB;
        end
      end
      RX_DEB: begin
        if (dat_s) begin
          state_d = RX_IDLE;
        end else if (deb_done) begin
          sh_clr  = 1'b1;
          state_d = RX_BITS;
        end
      end
      RX_BITS: begin
        if (sh_full && dat_s && clk_s) begin
          valid_d = 1'b1;
          byte_d  = sh_data;
          busy_d  = 1'b1;
          state_d = RX_IDLE;
        end else if (dat_rise && clk_s) begin
          state_d = RX_IDLE;
        end else if (clk_rise) begin
          sh_en = 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= RX_IDLE;
      abort_o     <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_byte_o  <= '0;
      busy_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      abort_o     <= abort_d;
      cmd_valid_o <= valid_d;
      cmd_byte_o  <= byte_d;
      busy_o      <= busy_d;
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  // R8
  busy_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> busy_o);
  // R2
  abort_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !busy_o);
  // R9
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_o |-> $stable(cmd_byte_o));
  // R7
  accept_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(sh_full));
endmodule

// File: tb/sim_serial_cmd_rx.sv
module sim_serial_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {pattern[15:0], bit count[7:0], accepted[7:0]}
  localparam logic [31:0] VECS [NVEC] = '{
    {16'h0022, 8'd8, 8'd1},
    {16'h00A5, 8'd8, 8'd1},
    {16'h0000, 8'd8, 8'd1},
    {16'h00FF, 8'd8, 8'd1},
    {16'h001A, 8'd7, 8'd0},
    {16'h0081, 8'd8, 8'd1},
    {16'h003C, 8'd9, 8'd0},
    {16'h0040, 8'd8, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdat = 1'b1;
  logic sclk = 1'b1;
  logic play_done = 1'b0;
  logic abort_w, valid_w, busy_w;
  logic [7:0] byte_w;

  int n_run = 0;
  int n_fail = 0;
  int n_valid = 0;
  int n_abort = 0;
  logic [7:0] last_byte = 8'h00;
  logic [7:0] exp_byte = 8'h00;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cmd_rx u0 (
    .clk(clk), .rst_n(rst_n), .sdat_i(sdat), .sclk_i(sclk),
    .play_done_i(play_done), .abort_o(abort_w), .cmd_valid_o(valid_w),
    .cmd_byte_o(byte_w), .busy_o(busy_w)
  );

  always @(negedge clk) begin
    if (valid_w) begin
      n_valid = n_valid + 1;
      last_byte = byte_w;
    end
    if (abort_w) n_abort = n_abort + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] pat, input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; cyc(3);
      sdat = pat[i]; cyc(3);
      sclk = 1'b1; cyc(6);
    end
  endtask

  task automatic open_frame();
    sdat = 1'b0; cyc(30);
  endtask

  task automatic close_frame();
    cyc(3); sdat = 1'b1; cyc(8);
  endtask

  task automatic pulse_done();
    play_done = 1'b1; cyc(1); play_done = 1'b0; cyc(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v0, a0;
    cyc(3);
    // R1 reset values
    check("R1 busy", busy_w, 0);
    check("R1 valid", valid_w, 0);
    check("R1 abort", abort_w, 0);
    check("R1 byte", byte_w, 0);
    rst_n = 1'b1;
    cyc(4);

    for (int k = 0; k < NVEC; k++) begin
      v0 = n_valid;
      open_frame();
      send_bits(VECS[k][31:16], int'(VECS[k][15:8]));
      close_frame();
      if (VECS[k][0]) exp_byte = VECS[k][23:16];
      // R5 / R6 accepted frames, R7 discarded ones
      check(VECS[k][0] ? "R5 strobe count" : "R7 discard count", n_valid - v0, int'(VECS[k][0]));
      check(VECS[k][0] ? "R5 byte" : "R9 byte held", byte_w, exp_byte);
      check("R8 busy after frame", busy_w, int'(VECS[k][0]));
      pulse_done();
      check("R8 busy cleared", busy_w, 0);
    end

    // R2 / R3: short low glitch
    v0 = n_valid; a0 = n_abort;
    sdat = 1'b0; cyc(6); sdat = 1'b1; cyc(30);
    check("R3 glitch no strobe", n_valid - v0, 0);
    check("R3 glitch busy", busy_w, 0);
    check("R2 abort once", n_abort - a0, 1);

    // R4: clock edges during debounce are ignored
    v0 = n_valid;
    sdat = 1'b0; cyc(2);
    for (int j = 0; j < 3; j++) begin
      sclk = 1'b0; cyc(1); sclk = 1'b1; cyc(2);
    end
    cyc(20);
    send_bits(16'h0096, 8);
    close_frame();
    check("R4 strobe", n_valid - v0, 1);
    check("R4 byte", byte_w, 8'h96);

    // R2: new frame while busy drops busy
    check("R2 busy before", busy_w, 1);
    a0 = n_abort;
    sdat = 1'b0; cyc(6);
    check("R2 busy dropped", busy_w, 0);
    check("R2 abort pulse", n_abort - a0, 1);
    cyc(24);
    // R6: final bit 0 -> nothing until data returns high
    v0 = n_valid;
    send_bits(16'h0011, 8);
    cyc(6);
    check("R6 no strobe before return", n_valid - v0, 0);
    check("R6 busy low before return", busy_w, 0);
    // R8: done pulse in the accept cycle; data seen at next edge, strobe two edges later
    sdat = 1'b1;
    cyc(2);
    play_done = 1'b1;
    cyc(1);
    play_done = 1'b0;
    check("R6 strobe cycle", valid_w, 1);
    check("R8 set wins over done", busy_w, 1);
    check("R5 byte 11", byte_w, 8'h11);
    pulse_done();
    check("R8 later done clears", busy_w, 0);

    // R6: final bit 1 -> accepted at eighth clock rise
    v0 = n_valid;
    open_frame();
    send_bits(16'h00C3, 8);
    check("R6 msb1 strobe", n_valid - v0, 1);
    check("R6 msb1 busy", busy_w, 1);
    check("R6 msb1 byte", byte_w, 8'hC3);
    close_frame();
    check("R6 msb1 single", n_valid - v0, 1);
    pulse_done();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule